// File: doc/BRIEF.md
# Serial SAR Converter Host Controller

This block runs a serial-output successive-approximation converter from the host side. On a start request it drives an active-low convert command to the converter and holds it low for a programmable minimum number of host cycles. It keeps the command low until the converter's busy/status line drops. While the conversion runs, it brings the converter's serial clock, serial data and status into the host clock domain through two-flop synchronisers. It captures one data bit on each rising edge of the serial clock, most significant bit first.

When status falls, the 16-bit word is complete. The block recodes the word according to a coding-select input and presents it with a single-cycle valid strobe. The converter delivers complementary binary: all ones at the bottom of the range, all zeros at the top, and 0111...1 at mid scale for bipolar ranges. Inverting every bit gives straight or offset binary. Inverting every bit except the MSB gives two's complement.

A timer runs from the start of each conversion. If status has not fallen when the timer reaches its limit, the controller releases the command, returns to idle and sets a sticky error flag. The default limit is above a full 16-bit conversion time of about 57 µs at a 200 MHz host clock. The host clock must run at least four times the serial bit rate.

Top module: `adc_serial_ctrl`

The controller has four states:
- IDLE: waiting for a request.
- ARM: the command is low and the minimum-width counter is running.
- WAIT_EOC: the command is low and the controller is waiting for status to fall.
- DONE: the single cycle in which the result is strobed.

Its transitions are:
- IDLE to ARM, on start.
- ARM to WAIT_EOC, when the pulse counter completes.
- ARM or WAIT_EOC to IDLE, on timeout.
- WAIT_EOC to DONE, on a status fall.
- DONE to IDLE, always.

## Requirements
- R1: While reset is active and after its release, conv_n is 1, data_valid is 0, busy is 0, err_timeout is 0 and data_out is 0.
- R2: A start seen in IDLE drives conv_n low from the next cycle. conv_n then stays low for at least PULSE_CYC cycles and until the synchronised status fall is detected.
- R3: Each bit is taken from adc_sdata on a rising edge of adc_sclk, and the first bit taken ends up as data_out[15] (MSB first).
- R4: status is driven low between clock edges. data_valid is 1 for exactly one cycle, three rising clock edges after status goes low, and gives exactly one strobe per conversion.
- R5: code_sel = 0 or 3 presents the captured word unchanged.
- R6: code_sel = 1 presents the bitwise inverse of the captured word.
- R7: code_sel = 2 presents the captured word with bits 14..0 inverted and bit 15 unchanged.
- R8: A start that arrives while busy is 1 has no effect: conv_n does not pulse again and the conversion gives one strobe with the correct word.
- R9: If status has not fallen TIMEOUT_CYC cycles after the start was taken, err_timeout is set, conv_n returns to 1 and busy to 0. No strobe is issued, and err_timeout stays 1 until reset even after later good conversions.
- R10: conv_n is 1 in the cycle data_valid is 1, and busy is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a conversion |
| code_sel | input | 2 | Output coding: 0/3 raw, 1 invert all, 2 invert all but MSB |
| adc_sclk | input | 1 | Converter serial clock (asynchronous) |
| adc_sdata | input | 1 | Converter serial data (asynchronous) |
| adc_status | input | 1 | Converter busy status, high during conversion |
| conv_n | output | 1 | Active-low convert command |
| busy | output | 1 | Controller not idle |
| data_out | output | 16 | Recoded result |
| data_valid | output | 1 | One-cycle result strobe |
| err_timeout | output | 1 | Sticky timeout flag |

## Verification
The bench drives every converter-side signal on the falling host edge. Each signal then passes two synchroniser flops and one output register. The strobe and the word are therefore sampled on the third falling edge after status is dropped, and the two falling edges before it are checked to show no strobe. The convert command is due low at the first falling edge after the start pulse is sampled, and it is checked low at every falling edge until the strobe. The error flag is checked clear one cycle before the timeout limit and set exactly at the limit, counted from the cycle the command went low.

// File: rtl/adc_ctrl_pkg.sv
`timescale 1ns/1ps
package adc_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARM      = 2'd1,
        ST_WAIT_EOC = 2'd2,
        ST_DONE     = 2'd3
    } ctrl_state_t;

    localparam logic [1:0] CODE_RAW  = 2'd0;
    localparam logic [1:0] CODE_INV  = 2'd1;
    localparam logic [1:0] CODE_TWOS = 2'd2;
endpackage

// File: rtl/adc_sync.sv
`timescale 1ns/1ps
module adc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= d_async;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/adc_shift.sv
`timescale 1ns/1ps
module adc_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clr) begin
            word <= '0;
        end else if (en) begin
            word <= {word[W-2:0], din};
        end
    end
endmodule

// File: rtl/adc_recode.sv
`timescale 1ns/1ps
module adc_recode
    import adc_ctrl_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] raw,
    output logic [W-1:0] coded
);
    localparam logic [W-1:0] LOW_MASK = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        unique case (sel)
            CODE_INV:  coded = ~raw;
            CODE_TWOS: coded = raw ^ LOW_MASK;
            default:   coded = raw;
        endcase
    end
endmodule

// File: rtl/adc_serial_ctrl.sv
`timescale 1ns/1ps
module adc_serial_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int PULSE_CYC   = 12,
    parameter int TIMEOUT_CYC = 11500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        code_sel,
    input  logic              adc_sclk,
    input  logic              adc_sdata,
    input  logic              adc_status,
    output logic              conv_n,
    output logic              busy,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic              err_timeout
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST   = TW'(TIMEOUT_CYC - 1);

    ctrl_state_t state, nxt;

    logic [2:0] sync_out;
    logic sclk_s, sdata_s, sts_s, sclk_q, sts_q;
    logic sclk_rise, sts_fall, tmo, pulse_done, active;
    logic [PW-1:0] pulse_cnt;
    logic [TW-1:0] timer;
    logic [DATA_W-1:0] shift_word, coded;

    adc_sync #(.W(3), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({adc_status, adc_sdata, adc_sclk}),
        .d_sync (sync_out)
    );
    assign {sts_s, sdata_s, sclk_s} = sync_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sts_q  <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
            sts_q  <= sts_s;
        end
    end
    assign sclk_rise = sclk_s & ~sclk_q;
    assign sts_fall  = sts_q & ~sts_s;

    assign active = (state == ST_ARM) || (state == ST_WAIT_EOC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
            timer     <= '0;
        end else if (!active) begin
            pulse_cnt <= '0;
            timer     <= '0;
        end else begin
            timer <= timer + 1'b1;
            if (state == ST_ARM) pulse_cnt <= pulse_cnt + 1'b1;
        end
    end
    assign pulse_done = (pulse_cnt == PULSE_LAST);
    assign tmo        = (timer == TMO_LAST);

    adc_shift #(.W(DATA_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == ST_IDLE && start),
        .en   (active && sclk_rise),
        .din  (sdata_s),
        .word (shift_word)
    );

    adc_recode #(.W(DATA_W)) u_recode (
        .sel  (code_sel),
        .raw  (shift_word),
        .coded(coded)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_ARM;
            ST_ARM: begin
                if (tmo)             nxt = ST_IDLE;
                else if (pulse_done) nxt = ST_WAIT_EOC;
            end
            ST_WAIT_EOC: begin
                if (sts_fall) nxt = ST_DONE;
                else if (tmo) nxt = ST_IDLE;
            end
            ST_DONE:     nxt = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_n      <= 1'b1;
            data_valid  <= 1'b0;
            data_out    <= '0;
            err_timeout <= 1'b0;
        end else begin
            conv_n     <= !(nxt == ST_ARM || nxt == ST_WAIT_EOC);
            data_valid <= (state == ST_WAIT_EOC) && sts_fall;
            if (state == ST_WAIT_EOC && sts_fall) data_out <= coded;
            if (active && tmo && !(state == ST_WAIT_EOC && sts_fall))
                err_timeout <= 1'b1;
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/adc_serial_ctrl_chk.sv
`timescale 1ns/1ps
module adc_serial_ctrl_chk #(
    parameter int PULSE_CYC = 12
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic conv_n,
    input logic busy,
    input logic data_valid,
    input logic err_timeout
);
    int unsigned low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_cnt <= 0;
        else if (!conv_n) low_cnt <= low_cnt + 1;
        else              low_cnt <= 0;
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_n) |-> (low_cnt >= PULSE_CYC)); // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid); // R4
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !$fell(conv_n)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> err_timeout); // R9
    AST_RELEASE_AT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (conv_n && $past(!conv_n))); // R10
    AST_IDLE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !busy); // R10
endmodule

bind adc_serial_ctrl adc_serial_ctrl_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .conv_n     (conv_n),
    .busy       (busy),
    .data_valid (data_valid),
    .err_timeout(err_timeout)
);

// File: tb/sim_adc_serial_ctrl.sv
`timescale 1ns/1ps
module sim_adc_serial_ctrl;
    localparam int PULSE_CYC   = 12;
    localparam int TIMEOUT_CYC = 11500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] code_sel = 2'd0;
    logic sclk = 1'b0, sdata = 1'b0, status = 1'b0;
    logic conv_n, busy, data_valid, err_timeout;
    logic [15:0] data_out;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    bit low_ok;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_serial_ctrl #(.DATA_W(16), .PULSE_CYC(PULSE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .code_sel(code_sel),
        .adc_sclk(sclk), .adc_sdata(sdata), .adc_status(status),
        .conv_n(conv_n), .busy(busy), .data_out(data_out),
        .data_valid(data_valid), .err_timeout(err_timeout)
    );

    always @(negedge clk) if (rst_n && data_valid) vcount++;

    function automatic logic [15:0] exp_code(input logic [15:0] raw, input logic [1:0] sel);
        case (sel)
            2'd1:    return ~raw;
            2'd2:    return raw ^ 16'h7FFF;
            default: return raw;
        endcase
    endfunction

    function automatic string sel_tag(input logic [1:0] sel);
        case (sel)
            2'd1:    return "R3/R6";
            2'd2:    return "R3/R7";
            default: return "R3/R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (conv_n) low_ok = 0;
    endtask

    task automatic run_conv(input logic [15:0] raw, input logic [1:0] sel, input bit extra_start);
        int v0;
        logic [15:0] e;
        e = exp_code(raw, sel);
        code_sel = sel;
        v0 = vcount;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk(conv_n == 0, "R2 conv_n low after start", 32'(conv_n), 0);
        low_ok = 1;
        repeat (4) step();
        status = 1;
        for (int i = 15; i >= 0; i--) begin
            sdata = raw[i];
            sclk = 0;
            if (extra_start && i == 8) start = 1;
            step();
            start = 0;
            step(); step();
            sclk = 1;
            step(); step(); step();
        end
        sclk = 0;
        step(); step(); step();
        status = 0;
        step();
        chk(data_valid == 0, "R4 no early strobe 1", 32'(data_valid), 0);
        step();
        chk(data_valid == 0, "R4 no early strobe 2", 32'(data_valid), 0);
        chk(low_ok, "R2 conv_n held low", 32'(low_ok), 1);
        @(negedge clk);
        chk(data_valid == 1, "R4 strobe at third edge", 32'(data_valid), 1);
        chk(data_out == e, sel_tag(sel), 32'(data_out), 32'(e));
        chk(conv_n == 1, "R10 conv_n released", 32'(conv_n), 1);
        @(negedge clk);
        chk(data_valid == 0, "R4 strobe one cycle", 32'(data_valid), 0);
        chk(busy == 0, "R10 busy low after strobe", 32'(busy), 0);
        chk(vcount - v0 == 1, extra_start ? "R8 one strobe" : "R4 one strobe",
            32'(vcount - v0), 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(conv_n == 1 && data_valid == 0 && busy == 0 && err_timeout == 0 && data_out == 0,
            "R1 in reset", {conv_n, data_valid, busy, err_timeout}, 32'h8);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(conv_n == 1 && data_valid == 0 && busy == 0 && err_timeout == 0 && data_out == 0,
            "R1 after reset", {conv_n, data_valid, busy, err_timeout}, 32'h8);

        // directed corners
        run_conv(16'hFFFF, 2'd1, 0);   // minus full scale -> offset binary zero
        run_conv(16'h0000, 2'd2, 0);   // plus full scale two's complement
        run_conv(16'h7FFF, 2'd2, 0);   // mid scale -> zero
        run_conv(16'h8000, 2'd3, 0);   // select 3 behaves as raw
        run_conv(16'hA5C3, 2'd0, 0);   // R3 bit order
        run_conv(16'h1234, 2'd1, 1);   // R8 start while busy

        // timeout (R9)
        begin
            int v0;
            v0 = vcount;
            @(negedge clk) start = 1;
            @(negedge clk) start = 0;
            status = 1;
            repeat (TIMEOUT_CYC - 1) @(negedge clk);
            chk(err_timeout == 0, "R9 no error before limit", 32'(err_timeout), 0);
            @(negedge clk);
            chk(err_timeout == 1, "R9 error at limit", 32'(err_timeout), 1);
            chk(conv_n == 1 && busy == 0, "R9 released to idle", {conv_n, busy}, 32'h2);
            status = 0;
            repeat (6) @(negedge clk);
            chk(vcount == v0, "R9 no strobe on timeout", 32'(vcount - v0), 0);
        end

        // random
        for (int n = 0; n < 30; n++) begin
            logic [15:0] r;
            logic [1:0] s;
            r = 16'($urandom);
            s = 2'($urandom);
            run_conv(r, s, ($urandom % 5) == 0);
        end
        chk(err_timeout == 1, "R9 error sticky", 32'(err_timeout), 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule